// File: doc/BRIEF.md
# Branch-Target-Buffer Fetch Address Generator

This block sits at the head of a processor front end and decides where instruction fetch goes next. Out of reset it starts at a fixed boot address. On every accepted cycle it hands the fetch queue one window of instruction addresses. A window is described by its start address, the number of instruction slots it holds and a flag that marks a predicted-taken branch.

All slots of the current window are looked up in parallel in a small direct-mapped branch target buffer. Each entry holds a tag, a target and a direction state. When a slot hits an entry that predicts taken, the window is cut after that slot and the next window starts at the stored target. When no slot does, the whole window is issued and fetch continues at the next sequential address.

Resolved branches come back from the pipeline on an update port. An update refreshes the entry it hits, or allocates a new entry when the branch was taken. At elaboration time a parameter selects the direction scheme: a 1-bit last-outcome bit or a 2-bit saturating counter. An input selects 4-byte or 2-byte instruction granularity.

Top module: `fetch_addr_gen`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_pc` equals `INIT_PC`; the buffer is empty after reset. After `rst_n` rises, `out_valid` becomes 1 at the third rising clock edge and then stays 1.
- R2: When no slot of the window hits a taken-predicting entry, `out_taken` is 0 and `out_slots` equals the full slot count. An accepted window (`out_valid` and `out_ready` both high) then moves `out_pc` forward by `WINDOW_BYTES`.
- R3: With `half_mode` = 0 the slot stride is 4 bytes and a window holds `WINDOW_BYTES/4` slots. With `half_mode` = 1 the stride is 2 bytes and a window holds `WINDOW_BYTES/2` slots. Slot i sits at `out_pc + i*stride`.
- R4: When one or more slots hit taken-predicting entries, the lowest such slot k wins. The window then shows `out_taken` = 1 and `out_slots` = k+1, and an accepted window makes the next `out_pc` equal that entry's target.
- R5: While `out_ready` is 0, `out_pc` holds its value and `out_valid` stays 1.
- R6: An update whose address misses the buffer allocates the indexed entry only if `upd_taken` = 1. The entry starts at counter value 2 (weakly taken) in 2-bit mode and at 1 (taken) in 1-bit mode. A not-taken update that misses changes nothing.
- R7: In 2-bit mode (`TWO_BIT` = 1) each update that hits moves the counter one step toward 3 when taken and toward 0 when not taken, saturating at both ends. Values 2 and 3 predict taken.
- R8: In 1-bit mode (`TWO_BIT` = 0) a hit entry predicts the outcome of the most recent update that hit it.
- R9: An update that hits replaces the stored target with `upd_target`, whatever the outcome.
- R10: When an update and the current window touch the same entry in one cycle, the window uses the contents held before that update. The update takes effect from the next cycle.
- R11: The entry index is taken from the address bits directly above the instruction alignment (bit 1 upward in 2-byte mode, bit 2 upward in 4-byte mode). The remaining upper bits form the tag. A taken update with a different tag at the same index replaces the old entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| half_mode | input | 1 | 1 = 2-byte instruction granularity, 0 = 4-byte |
| out_ready | input | 1 | Fetch queue accepts the current window |
| out_valid | output | 1 | A window is offered |
| out_pc | output | ADDR_W | Start address of the window |
| out_slots | output | $clog2(WINDOW_BYTES/2+1) | Number of valid instruction slots |
| out_taken | output | 1 | Window ends at a predicted-taken branch |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_target | input | ADDR_W | Resolved target of the branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The bench builds two copies side by side, one in 2-bit and one in 1-bit mode. Both use 16-bit addresses, a 16-byte window and an 8-entry buffer, so a window has only four or eight slots and the whole index space is covered within a few windows. A branch is placed in every slot position in turn and index aliasing occurs every eight strides. Random updates and stalls can then reach every entry, every counter value and every same-cycle collision many times, in both granularities.

// File: rtl/fag_pkg.sv
package fag_pkg;

  typedef enum logic {
    GRAN_WORD = 1'b0,
    GRAN_HALF = 1'b1
  } gran_e;

  // direction state advance on a resolved hit
  function automatic logic [1:0] dir_next(input logic [1:0] st,
                                          input logic       taken,
                                          input logic       two_bit);
    logic [1:0] r;
    if (!two_bit) begin
      r = {1'b0, taken};
    end else if (taken) begin
      r = (st == 2'd3) ? st : st + 2'd1;
    end else begin
      r = (st == 2'd0) ? st : st - 2'd1;
    end
    return r;
  endfunction

  function automatic logic dir_predict(input logic [1:0] st,
                                       input logic       two_bit);
    return two_bit ? st[1] : st[0];
  endfunction

  function automatic logic [1:0] dir_alloc(input logic two_bit);
    return two_bit ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/fag_rst_sync.sv
module fag_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/fag_btb_store.sv
module fag_btb_store
  import fag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64,
  parameter bit TWO_BIT = 1'b1,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - 1 - IDX_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             half_mode,
  input  logic                             upd_valid,
  input  logic [ADDR_W-1:0]                upd_pc,
  input  logic [ADDR_W-1:0]                upd_target,
  input  logic                             upd_taken,
  output logic [ENTRIES-1:0]               ent_valid,
  output logic [ENTRIES-1:0][TAG_W-1:0]    ent_tag,
  output logic [ENTRIES-1:0][ADDR_W-1:0]   ent_target,
  output logic [ENTRIES-1:0][1:0]          ent_state
);
  logic [IDX_W-1:0] u_idx;
  logic [TAG_W-1:0] u_tag;
  logic             lsb_unused;
  gran_e            gran;

  assign gran       = gran_e'(half_mode);
  assign lsb_unused = upd_pc[0];

  // index from bits just above alignment, tag from the rest
  always_comb begin
    if (gran == GRAN_HALF) begin
      u_idx = upd_pc[IDX_W:1];
      u_tag = upd_pc[ADDR_W-1:IDX_W+1];
    end else begin
      u_idx = upd_pc[IDX_W+1:2];
      u_tag = {1'b0, upd_pc[ADDR_W-1:IDX_W+2]};
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              sel, hit, wr_en;
    logic              v_d;
    logic [TAG_W-1:0]  tag_d;
    logic [ADDR_W-1:0] tgt_d;
    logic [1:0]        st_d;

    assign sel = upd_valid && (u_idx == IDX_W'(e));
    assign hit = ent_valid[e] && (ent_tag[e] == u_tag);

    always_comb begin
      v_d   = ent_valid[e];
      tag_d = ent_tag[e];
      tgt_d = ent_target[e];
      st_d  = ent_state[e];
      wr_en = 1'b0;
      if (sel) begin
        if (hit) begin
          wr_en = 1'b1;
          tgt_d = upd_target;
          st_d  = dir_next(ent_state[e], upd_taken, TWO_BIT);
        end else if (upd_taken) begin
          wr_en = 1'b1;
          v_d   = 1'b1;
          tag_d = u_tag;
          tgt_d = upd_target;
          st_d  = dir_alloc(TWO_BIT);
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[e] <= 1'b0;
      end else if (wr_en) begin
        ent_valid[e] <= v_d;
      end
    end

    // payload carries no reset; it is qualified by the valid bit
    always_ff @(posedge clk) begin
      if (wr_en) begin
        ent_tag[e]    <= tag_d;
        ent_target[e] <= tgt_d;
        ent_state[e]  <= st_d;
      end
    end
  end
endmodule

// File: rtl/fag_window_scan.sv
module fag_window_scan
  import fag_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int ENTRIES      = 64,
  parameter int WINDOW_BYTES = 64,
  parameter bit TWO_BIT      = 1'b1,
  localparam int IDX_W       = $clog2(ENTRIES),
  localparam int TAG_W       = ADDR_W - 1 - IDX_W,
  localparam int MAX_SLOTS   = WINDOW_BYTES / 2,
  localparam int WORD_SLOTS  = WINDOW_BYTES / 4,
  localparam int SLOT_W      = $clog2(MAX_SLOTS + 1)
) (
  input  logic [ADDR_W-1:0]                pc,
  input  logic                             half_mode,
  input  logic [ENTRIES-1:0]               ent_valid,
  input  logic [ENTRIES-1:0][TAG_W-1:0]    ent_tag,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]   ent_target,
  input  logic [ENTRIES-1:0][1:0]          ent_state,
  output logic                             win_taken,
  output logic [SLOT_W-1:0]                win_slots,
  output logic [ADDR_W-1:0]                win_target
);
  logic [MAX_SLOTS-1:0]             slot_tk;
  logic [MAX_SLOTS-1:0][ADDR_W-1:0] slot_tgt;
  logic [MAX_SLOTS-1:0]             slot_unused;
  gran_e                            gran;

  assign gran = gran_e'(half_mode);

  for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_slot
    logic [ADDR_W-1:0] addr;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic              in_win;

    assign addr = pc + ((gran == GRAN_HALF) ? ADDR_W'(2 * s) : ADDR_W'(4 * s));
    assign slot_unused[s] = addr[0];

    always_comb begin
      if (gran == GRAN_HALF) begin
        idx = addr[IDX_W:1];
        tag = addr[ADDR_W-1:IDX_W+1];
      end else begin
        idx = addr[IDX_W+1:2];
        tag = {1'b0, addr[ADDR_W-1:IDX_W+2]};
      end
    end

    if (s < WORD_SLOTS) begin : g_both
      assign in_win = 1'b1;
    end else begin : g_half_only
      assign in_win = (gran == GRAN_HALF);
    end

    assign slot_tk[s]  = in_win && ent_valid[idx] && (ent_tag[idx] == tag)
                         && dir_predict(ent_state[idx], TWO_BIT);
    assign slot_tgt[s] = ent_target[idx];
  end

  // lowest taken slot wins: scan from the top so the lowest is written last
  always_comb begin
    win_taken  = 1'b0;
    win_slots  = (gran == GRAN_HALF) ? SLOT_W'(MAX_SLOTS) : SLOT_W'(WORD_SLOTS);
    win_target = '0;
    for (int s = MAX_SLOTS - 1; s >= 0; s--) begin
      if (slot_tk[s]) begin
        win_taken  = 1'b1;
        win_slots  = SLOT_W'(s + 1);
        win_target = slot_tgt[s];
      end
    end
  end
endmodule

// File: rtl/fag_pc_seq.sv
module fag_pc_seq #(
  parameter int                ADDR_W       = 32,
  parameter int                WINDOW_BYTES = 64,
  parameter logic [ADDR_W-1:0] INIT_PC      = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_pc,
  output logic [ADDR_W-1:0] pc,
  output logic              valid
);
  logic [ADDR_W-1:0] pc_d;
  logic              valid_d;
  logic              fire;

  assign fire = valid && ready;

  always_comb begin
    valid_d = 1'b1;
    pc_d    = pc;
    if (fire) begin
      pc_d = redirect ? redirect_pc : pc + ADDR_W'(WINDOW_BYTES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= INIT_PC;
      valid <= 1'b0;
    end else begin
      pc    <= pc_d;
      valid <= valid_d;
    end
  end
endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen #(
  parameter int                ADDR_W       = 32,
  parameter int                WINDOW_BYTES = 64,
  parameter int                BTB_ENTRIES  = 64,
  parameter bit                TWO_BIT      = 1'b1,
  parameter logic [ADDR_W-1:0] INIT_PC      = ADDR_W'(32'h0000_1000)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  half_mode,
  input  logic                                  out_ready,
  output logic                                  out_valid,
  output logic [ADDR_W-1:0]                     out_pc,
  output logic [$clog2(WINDOW_BYTES/2+1)-1:0]   out_slots,
  output logic                                  out_taken,
  input  logic                                  upd_valid,
  input  logic [ADDR_W-1:0]                     upd_pc,
  input  logic [ADDR_W-1:0]                     upd_target,
  input  logic                                  upd_taken
);
  localparam int IDX_W  = $clog2(BTB_ENTRIES);
  localparam int TAG_W  = ADDR_W - 1 - IDX_W;
  localparam int SLOT_W = $clog2(WINDOW_BYTES / 2 + 1);

  logic                                 srst_n;
  logic [BTB_ENTRIES-1:0]               ent_valid;
  logic [BTB_ENTRIES-1:0][TAG_W-1:0]    ent_tag;
  logic [BTB_ENTRIES-1:0][ADDR_W-1:0]   ent_target;
  logic [BTB_ENTRIES-1:0][1:0]          ent_state;
  logic                                 win_taken;
  logic [SLOT_W-1:0]                    win_slots;
  logic [ADDR_W-1:0]                    win_target;

  fag_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  fag_btb_store #(
    .ADDR_W  (ADDR_W),
    .ENTRIES (BTB_ENTRIES),
    .TWO_BIT (TWO_BIT)
  ) u_store (
    .clk        (clk),
    .rst_n      (srst_n),
    .half_mode  (half_mode),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_target (upd_target),
    .upd_taken  (upd_taken),
    .ent_valid  (ent_valid),
    .ent_tag    (ent_tag),
    .ent_target (ent_target),
    .ent_state  (ent_state)
  );

  fag_window_scan #(
    .ADDR_W       (ADDR_W),
    .ENTRIES      (BTB_ENTRIES),
    .WINDOW_BYTES (WINDOW_BYTES),
    .TWO_BIT      (TWO_BIT)
  ) u_scan (
    .pc         (out_pc),
    .half_mode  (half_mode),
    .ent_valid  (ent_valid),
    .ent_tag    (ent_tag),
    .ent_target (ent_target),
    .ent_state  (ent_state),
    .win_taken  (win_taken),
    .win_slots  (win_slots),
    .win_target (win_target)
  );

  fag_pc_seq #(
    .ADDR_W       (ADDR_W),
    .WINDOW_BYTES (WINDOW_BYTES),
    .INIT_PC      (INIT_PC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (srst_n),
    .ready       (out_ready),
    .redirect    (win_taken),
    .redirect_pc (win_target),
    .pc          (out_pc),
    .valid       (out_valid)
  );

  assign out_slots = win_slots;
  assign out_taken = win_taken;
endmodule

// File: rtl/fetch_addr_gen_chk.sv
module fetch_addr_gen_chk #(
  parameter int ADDR_W       = 32,
  parameter int WINDOW_BYTES = 64,
  parameter int SLOT_W       = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              half_mode,
  input logic              out_ready,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_pc,
  input logic [SLOT_W-1:0] out_slots,
  input logic              out_taken,
  input logic [ADDR_W-1:0] redir_target
);
  logic [SLOT_W-1:0] full_slots;
  assign full_slots = half_mode ? SLOT_W'(WINDOW_BYTES / 2) : SLOT_W'(WINDOW_BYTES / 4);

  // R1
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  // R2
  full_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_taken) |-> (out_slots == full_slots));

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_taken) |=> (out_pc == ADDR_W'($past(out_pc) + WINDOW_BYTES)));

  // R4
  taken_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_taken) |-> (out_slots != '0 && out_slots <= full_slots));

  // R4
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_taken) |=> (out_pc == $past(redir_target)));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_pc) && out_valid));
endmodule

bind fetch_addr_gen fetch_addr_gen_chk #(
  .ADDR_W       (ADDR_W),
  .WINDOW_BYTES (WINDOW_BYTES),
  .SLOT_W       (SLOT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .half_mode    (half_mode),
  .out_ready    (out_ready),
  .out_valid    (out_valid),
  .out_pc       (out_pc),
  .out_slots    (out_slots),
  .out_taken    (out_taken),
  .redir_target (win_target)
);

// File: tb/fetch_addr_gen_test.sv
`timescale 1ns/1ps
module fetch_addr_gen_test;
  localparam int AW = 16;
  localparam int WB = 16;
  localparam int NE = 8;
  localparam int SW = $clog2(WB / 2 + 1);
  localparam logic [AW-1:0] IPC = 16'h0100;
  localparam int MASK = 32'hFFFF;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, half, rdy, uv, utk;
  logic [AW-1:0] upc, utgt;
  logic          ov0, ov1, ot0, ot1;
  logic [AW-1:0] op0, op1;
  logic [SW-1:0] os0, os1;

  fetch_addr_gen #(.ADDR_W(AW), .WINDOW_BYTES(WB), .BTB_ENTRIES(NE),
                   .TWO_BIT(1'b1), .INIT_PC(IPC)) uut (
    .clk(clk), .rst_n(rst_n), .half_mode(half), .out_ready(rdy),
    .out_valid(ov0), .out_pc(op0), .out_slots(os0), .out_taken(ot0),
    .upd_valid(uv), .upd_pc(upc), .upd_target(utgt), .upd_taken(utk));

  fetch_addr_gen #(.ADDR_W(AW), .WINDOW_BYTES(WB), .BTB_ENTRIES(NE),
                   .TWO_BIT(1'b0), .INIT_PC(IPC)) uut_1b (
    .clk(clk), .rst_n(rst_n), .half_mode(half), .out_ready(rdy),
    .out_valid(ov1), .out_pc(op1), .out_slots(os1), .out_taken(ot1),
    .upd_valid(uv), .upd_pc(upc), .upd_target(utgt), .upd_taken(utk));

  int n_chk = 0, n_fail = 0;
  // reference tables: index 0 = 2-bit copy, 1 = 1-bit copy
  int mv[2][NE], mtag[2][NE], mtgt[2][NE], mst[2][NE];
  int mpc[2];
  int unsigned rng = 32'h1234_5678;

  function automatic int gidx(int a);
    return half ? ((a >> 1) & (NE - 1)) : ((a >> 2) & (NE - 1));
  endfunction

  function automatic int gtag(int a);
    return half ? (a >> 4) : (a >> 5);
  endfunction

  function automatic bit pred(int k, int st);
    return (k == 0) ? (st >= 2) : (st == 1);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic exp_win(int k, output int sl, output int tk, output int nx);
    int stride, n;
    stride = half ? 2 : 4;
    n  = WB / stride;
    sl = n; tk = 0; nx = (mpc[k] + WB) & MASK;
    for (int i = 0; i < n; i++) begin
      int a, e;
      a = (mpc[k] + i * stride) & MASK;
      e = gidx(a);
      if (mv[k][e] != 0 && mtag[k][e] == gtag(a) && pred(k, mst[k][e])) begin
        sl = i + 1; tk = 1; nx = mtgt[k][e];
        break;
      end
    end
  endtask

  task automatic cyc(string tag0, string tag1, bit r, bit v, int p, int t, bit tk);
    @(negedge clk);
    rdy = r; uv = v; upc = AW'(p); utgt = AW'(t); utk = tk;
    #2;
    for (int k = 0; k < 2; k++) begin
      int esl, etk, enx, av, ap, as, at, e, g;
      string tg;
      tg = (k == 0) ? tag0 : tag1;
      exp_win(k, esl, etk, enx);
      if (k == 0) begin av = ov0; ap = op0; as = os0; at = ot0; end
      else        begin av = ov1; ap = op1; as = os1; at = ot1; end
      check(tg, "valid", av, 1);
      check(tg, "pc", ap, mpc[k]);
      check(tg, "slots", as, esl);
      check(tg, "taken", at, etk);
      // update applies after the lookup of this cycle (old contents seen)
      if (v) begin
        e = gidx(p); g = gtag(p);
        if (mv[k][e] != 0 && mtag[k][e] == g) begin
          mtgt[k][e] = t;
          if (k == 0) mst[k][e] = tk ? ((mst[k][e] == 3) ? 3 : mst[k][e] + 1)
                                     : ((mst[k][e] == 0) ? 0 : mst[k][e] - 1);
          else        mst[k][e] = tk;
        end else if (tk) begin
          mv[k][e] = 1; mtag[k][e] = g; mtgt[k][e] = t;
          mst[k][e] = (k == 0) ? 2 : 1;
        end
      end
      if (r) mpc[k] = enx;
    end
  endtask

  task automatic do_reset(bit hm);
    @(negedge clk);
    rst_n = 1'b0; half = hm; rdy = 1'b0; uv = 1'b0; utk = 1'b0; upc = '0; utgt = '0;
    for (int k = 0; k < 2; k++) begin
      mpc[k] = IPC;
      for (int e = 0; e < NE; e++) begin mv[k][e] = 0; mst[k][e] = 0; end
    end
    @(negedge clk);
    check("R1", "valid in reset", ov0, 0);
    check("R1", "valid in reset 1b", ov1, 0);
    check("R1", "pc in reset", op0, IPC);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", "valid two edges after release", ov0, 0);
    check("R1", "valid two edges after release 1b", ov1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1: actual 150000 cycles expected fewer");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; half = 1'b0; rdy = 1'b0; uv = 1'b0; utk = 1'b0; upc = '0; utgt = '0;
    for (int m = 0; m < 2; m++) begin
      int st;
      st = (m == 1) ? 2 : 4;
      do_reset(m[0]);
      // R2 and R3: empty buffer, full sequential windows
      repeat (3) cyc("R2", "R3", 1, 0, 0, 0, 0);
      // R5: stall holds
      repeat (3) cyc("R5", "R5", 0, 0, 0, 0, 0);
      // R4 and R6: branch in every slot, installed highest slot first
      for (int s = WB / st - 1; s >= 0; s--) begin
        cyc("R6", "R6", 0, 1, (mpc[0] + WB + st * s) & MASK, IPC, 1);
        cyc("R4", "R4", 1, 0, 0, 0, 0);
        cyc("R4", "R4", 1, 0, 0, 0, 0);
      end
      // R6: not-taken miss is dropped
      cyc("R6", "R6", 0, 1, IPC + st, IPC + 8 * st, 0);
      cyc("R6", "R6", 0, 0, 0, 0, 0);
      // R7 / R8: train a branch in the current window while stalled
      cyc("R6", "R6", 0, 1, IPC + st, IPC, 1);
      for (int i = 0; i < 12; i++) begin
        bit o;
        o = (12'b1110_0110_0100 >> i) & 1;
        cyc("R7", "R8", 0, 1, IPC + st, IPC, o);
      end
      repeat (3) cyc("R7", "R8", 0, 1, IPC + st, IPC, 1);
      // R10: accepted window and update on the same entry in one cycle
      cyc("R10", "R10", 1, 1, IPC + st, IPC, 0);
      cyc("R10", "R10", 0, 0, 0, 0, 0);
      // R11: alias at same index, different tag
      cyc("R11", "R11", 0, 1, IPC + st + NE * st, IPC + 4 * WB, 0);
      cyc("R11", "R11", 0, 1, IPC + st + NE * st, IPC + 4 * WB, 1);
      cyc("R11", "R11", 0, 0, 0, 0, 0);
      // R9: target refresh on hit
      cyc("R9", "R9", 0, 1, IPC + st + NE * st, IPC + 2 * WB, 0);
      cyc("R9", "R9", 0, 1, IPC + st, IPC + 3 * WB, 1);
      repeat (3) cyc("R9", "R9", 1, 0, 0, 0, 0);
      // R4: mixed random traffic
      for (int i = 0; i < 1500; i++) begin
        int p, t;
        rng = rng * 32'd1664525 + 32'd1013904223;
        p = (mpc[i % 2] + ((rng >> 8) % 8) * st) & MASK;
        t = IPC + ((rng >> 12) % 16) * 4;
        cyc("R4", "R4", (rng[20] | rng[21]), rng[22], p, t, (rng[24] | rng[25]));
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule